// File: doc/BRIEF.md
# Frame Reject Sampling Window

This block sits beside a receive path that delivers 4-bit nibbles on a media-independent interface, clocked by the receive clock. It looks for the start-of-frame delimiter in the nibble stream. After that it listens to an active-low reject input from external address-comparison logic, but only inside a bounded window that opens just after the delimiter. When the data-valid signal drops at the end of the frame, it issues a one-cycle decision strobe that carries an accept or reject bit.

Four configuration inputs shape the decision. A run enable keeps the whole block alive, independent of any transmit or receive DMA state. Promiscuous mode forces acceptance. A full-duplex flag disables rejection unless full-duplex padding is also enabled. A runt-accept mode pulls the window close in to byte 8. A built-in pulse checker watches the reject input and flags low pulses that are shorter than the minimum valid width.

Top module: `frame_reject_window`

## Requirements
- R1: While the window is open, a low level on `reject_n` in any cycle causes the frame to be reported as rejected (`frame_accept` = 0 with `frame_done` = 1).
- R2: The window covers nibble positions 1 through `WIN_NIB` (default 128, which is 64 bytes) after the delimiter nibble, where position 0 is the delimiter itself. Reject activity during the preamble, on the delimiter nibble, after the window closes, or while `rx_dv` is low does not reject the frame.
- R3: A frame is reported as accepted if `reject_n` stayed high for the whole window.
- R4: With `promisc` = 1, every frame is reported as accepted whatever `reject_n` does.
- R5: With `full_duplex` = 1 and `fd_pad_en` = 0, `reject_n` is ignored. With `full_duplex` = 1 and `fd_pad_en` = 1, rejection works as in R1.
- R6: With `runt_accept` = 1, the window closes after nibble position `RUNT_NIB` (default 16, which is 8 bytes). This also holds for frames shorter than 64 bytes.
- R7: With `run_en` = 0, no delimiter is detected, no decision strobe is issued, no glitch is flagged, and any frame in progress is dropped without a strobe.
- R8: When `reject_n` returns high after a low run of 1 to `MIN_LOW`-1 cycles (default `MIN_LOW` = 3 nibble clocks, at least 110 ns at 25 MHz), `reject_glitch` pulses high for one cycle, in the cycle after `reject_n` rises. Low runs of `MIN_LOW` cycles or longer raise no flag.
- R9: `frame_done` is high for exactly one cycle per frame: the cycle after the first input cycle in which `rx_dv` is low following the frame. `frame_accept` is 0 whenever `frame_done` is 0. After reset all outputs are low.
- R10: The reject state of one frame does not carry into the next. A clean frame that follows a rejected frame is accepted.
- R11: The delimiter is a nibble of value 4'hD with `rx_dv` = 1, immediately preceded by a nibble of value 4'h5 with `rx_dv` = 1. A 4'hD nibble received while a frame is already in progress does not restart the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Block run enable |
| promisc | input | 1 | Promiscuous mode: accept every frame |
| full_duplex | input | 1 | Link is in full-duplex operation |
| fd_pad_en | input | 1 | Allow rejection in full duplex |
| runt_accept | input | 1 | Runt mode: window closes at byte 8 |
| rx_dv | input | 1 | Receive data valid |
| rxd | input | 4 | Receive nibble |
| reject_n | input | 1 | Active-low external reject request |
| frame_done | output | 1 | One-cycle end-of-frame decision strobe |
| frame_accept | output | 1 | Decision bit, valid with frame_done |
| reject_glitch | output | 1 | One-cycle flag for a too-short reject pulse |

## Verification
The assertions take four things for granted about the inputs. Every frame is preceded by a 5-nibble, `rx_dv` is continuous from the delimiter to the end of the frame, and the configuration inputs do not change while a frame is in progress. The assertion that ties promiscuous mode to acceptance also assumes `promisc` is steady around the end of a frame. The stimulus follows these rules. It sends each frame as 15 preamble nibbles, the delimiter, and a contiguous body. It changes configuration only during idle gaps and toggles `run_en` only between frames. Reject pulses are placed by nibble position, so that they land exactly on the window edges.

// File: rtl/frs_pkg.sv
package frs_pkg;
    localparam logic [3:0] PRE_NIBBLE = 4'h5;
    localparam logic [3:0] SOF_NIBBLE = 4'hD;
endpackage

// File: rtl/frs_sof_track.sv
module frs_sof_track
    import frs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       rx_dv,
    input  logic [3:0] rxd,
    output logic       sof_o,
    output logic       in_frame_o,
    output logic       frame_end_o
);
    typedef struct packed {
        logic prev_pre;
        logic in_frame;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        sof_o       = run_en && rx_dv && (rxd == SOF_NIBBLE) && s_q.prev_pre && !s_q.in_frame;
        frame_end_o = run_en && s_q.in_frame && !rx_dv;
        s_d         = s_q;
        if (!run_en) begin
            s_d = '0;
        end else begin
            s_d.prev_pre = rx_dv && (rxd == PRE_NIBBLE);
            if (sof_o)            s_d.in_frame = 1'b1;
            else if (frame_end_o) s_d.in_frame = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_frame_o = s_q.in_frame;

    // R11
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.in_frame) |-> ($past(rxd) == SOF_NIBBLE) && $past(rx_dv));
endmodule

// File: rtl/frs_window.sv
module frs_window #(
    parameter int WIN_NIB  = 128,
    parameter int RUNT_NIB = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic sof_i,
    input  logic in_frame_i,
    input  logic rx_dv,
    input  logic runt_accept,
    output logic in_window_o
);
    localparam int CNT_W = $clog2(WIN_NIB + 1);
    localparam logic [CNT_W-1:0] WIN_C  = CNT_W'(WIN_NIB);
    localparam logic [CNT_W-1:0] RUNT_C = CNT_W'(RUNT_NIB);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } win_t;

    win_t w_d, w_q;
    logic [CNT_W-1:0] close_pos;

    always_comb begin
        close_pos   = runt_accept ? RUNT_C : WIN_C;
        in_window_o = in_frame_i && rx_dv && (w_q.cnt < close_pos);
        w_d         = w_q;
        if (!run_en || sof_i) begin
            w_d.cnt = '0;
        end else if (in_frame_i && rx_dv && (w_q.cnt < WIN_C)) begin
            w_d.cnt = w_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.cnt <= WIN_C);
    // R6
    runt_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_window_o && runt_accept) |-> (w_q.cnt < RUNT_C));
endmodule

// File: rtl/frs_pulse_chk.sv
module frs_pulse_chk #(
    parameter int MIN_LOW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic reject_n,
    output logic glitch_o
);
    localparam int LW = $clog2(MIN_LOW + 1);
    localparam logic [LW-1:0] MIN_C = LW'(MIN_LOW);

    typedef struct packed {
        logic [LW-1:0] low_run;
        logic          glitch;
    } pc_t;

    pc_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (!run_en) begin
            p_d = '0;
        end else if (!reject_n) begin
            p_d.glitch = 1'b0;
            if (p_q.low_run < MIN_C) p_d.low_run = p_q.low_run + 1'b1;
        end else begin
            p_d.glitch  = (p_q.low_run != '0) && (p_q.low_run < MIN_C);
            p_d.low_run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign glitch_o = p_q.glitch;

    // R8
    glitch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.glitch |-> $past(reject_n) && !$past(reject_n, 2));
    // R8
    glitch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.glitch |=> !p_q.glitch);
endmodule

// File: rtl/frame_reject_window.sv
module frame_reject_window #(
    parameter int WIN_NIB  = 128,
    parameter int RUNT_NIB = 16,
    parameter int MIN_LOW  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       promisc,
    input  logic       full_duplex,
    input  logic       fd_pad_en,
    input  logic       runt_accept,
    input  logic       rx_dv,
    input  logic [3:0] rxd,
    input  logic       reject_n,
    output logic       frame_done,
    output logic       frame_accept,
    output logic       reject_glitch
);
    typedef struct packed {
        logic rej;
        logic done;
        logic acc;
    } dec_t;

    dec_t d_d, d_q;
    logic sof, in_frame, frame_end, in_window, eligible;

    frs_sof_track u_trk (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .rx_dv(rx_dv), .rxd(rxd),
        .sof_o(sof), .in_frame_o(in_frame), .frame_end_o(frame_end)
    );

    frs_window #(.WIN_NIB(WIN_NIB), .RUNT_NIB(RUNT_NIB)) u_win (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .sof_i(sof),
        .in_frame_i(in_frame), .rx_dv(rx_dv), .runt_accept(runt_accept),
        .in_window_o(in_window)
    );

    frs_pulse_chk #(.MIN_LOW(MIN_LOW)) u_pc (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .reject_n(reject_n),
        .glitch_o(reject_glitch)
    );

    always_comb begin
        eligible = !promisc && (!full_duplex || fd_pad_en);
        d_d      = d_q;
        d_d.done = 1'b0;
        d_d.acc  = 1'b0;
        if (!run_en) begin
            d_d = '0;
        end else begin
            if (sof)                                   d_d.rej = 1'b0;
            else if (in_window && !reject_n && eligible) d_d.rej = 1'b1;
            if (frame_end) begin
                d_d.done = 1'b1;
                d_d.acc  = !d_q.rej || promisc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign frame_done   = d_q.done;
    assign frame_accept = d_q.acc;

    // R2
    rej_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_q.rej) |-> $past(in_window) && !$past(reject_n));
    // R4
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.done && $past(promisc)) |-> d_q.acc);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_q.done |=> !d_q.done);
    // R9
    acc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_q.acc |-> d_q.done);
    // R7
    run_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !d_q.done && !reject_glitch);
endmodule

// File: tb/sim_frame_reject_window.sv
module sim_frame_reject_window;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b1, promisc = 1'b0, full_duplex = 1'b0, fd_pad_en = 1'b0, runt_accept = 1'b0;
    logic rx_dv = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic reject_n = 1'b1;
    logic frame_done, frame_accept, reject_glitch;

    int n_tests = 0, n_fail = 0, cyc = 0;
    int strobes = 0, glitches = 0, last_acc = -1;
    int m_inframe = 0, m_idx = 0, m_rej = 0, m_low = 0, m_prevok = 0;
    int e_done = 0, e_acc = 0, e_glitch = 0;

    always #4 clk = ~clk;

    frame_reject_window u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .promisc(promisc),
        .full_duplex(full_duplex), .fd_pad_en(fd_pad_en), .runt_accept(runt_accept),
        .rx_dv(rx_dv), .rxd(rxd), .reject_n(reject_n),
        .frame_done(frame_done), .frame_accept(frame_accept), .reject_glitch(reject_glitch)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference, advanced once per rising edge
    always @(posedge clk) begin
        int lim;
        e_done = 0; e_acc = 0; e_glitch = 0;
        if (!rst_n || !run_en) begin
            m_inframe = 0; m_idx = 0; m_rej = 0; m_low = 0; m_prevok = 0;
        end else begin
            if (!reject_n) m_low++;
            else begin
                e_glitch = (m_low > 0 && m_low < 3) ? 1 : 0;
                m_low = 0;
            end
            if (m_inframe != 0) begin
                if (rx_dv) begin
                    m_idx++;
                    lim = runt_accept ? 16 : 128;
                    if (m_idx <= lim && !reject_n && !promisc && (!full_duplex || fd_pad_en))
                        m_rej = 1;
                end else begin
                    e_done = 1;
                    e_acc = (m_rej == 0 || promisc) ? 1 : 0;
                    m_inframe = 0;
                end
            end else if (rx_dv && rxd == 4'hD && m_prevok != 0) begin
                m_inframe = 1; m_idx = 0; m_rej = 0;
            end
            m_prevok = (rx_dv && rxd == 4'h5) ? 1 : 0;
        end
    end

    // compare every clock, away from the edge
    always @(posedge clk) begin
        #2;
        cyc++;
        chk(frame_done == e_done, "R9 frame_done", int'(frame_done), e_done);
        chk(frame_accept == e_acc, "R9 frame_accept", int'(frame_accept), e_acc);
        chk(reject_glitch == e_glitch, "R8 reject_glitch", int'(reject_glitch), e_glitch);
        if (frame_done) begin strobes++; last_acc = int'(frame_accept); end
        if (reject_glitch) glitches++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_dv = 1'b0; rxd = 4'h0; reject_n = 1'b1;
        end
    endtask

    // body positions: 0 is the delimiter, negatives are preamble
    task automatic frame(input int nbody, input int rs, input int rl,
                         input int exp_acc, input string tag);
        int s0;
        s0 = strobes;
        for (int i = -15; i <= nbody + 3; i++) begin
            @(negedge clk);
            rx_dv = (i <= nbody);
            rxd = (i > nbody) ? 4'h0 : (i < 0) ? 4'h5 : (i == 0) ? 4'hD : 4'((i * 7) & 15);
            reject_n = !(i >= rs && i < rs + rl);
        end
        idle(4);
        if (exp_acc < 0) begin
            chk(strobes == s0, tag, strobes - s0, 0);
        end else begin
            chk(strobes == s0 + 1, tag, strobes - s0, 1);
            chk(last_acc == exp_acc, tag, last_acc, exp_acc);
        end
    endtask

    initial begin
        int g0;
        repeat (3) @(negedge clk);
        chk(!frame_done && !frame_accept && !reject_glitch, "R9 reset outputs", int'(frame_done), 0);
        rst_n = 1'b1;
        idle(3);
        frame(40, 1000, 0, 1, "R3 clean frame");
        frame(40, 5, 4, 0, "R1 reject inside window");
        frame(40, -4, 5, 1, "R2 reject on preamble and delimiter");
        frame(160, 128, 3, 0, "R2 reject at last window nibble");
        frame(160, 129, 3, 1, "R2 reject just after window");
        frame(40, 1, 3, 0, "R2 reject at first window nibble");
        frame(20, 21, 3, 1, "R2 reject after rx_dv drops");
        frame(40, 10, 3, 0, "R10 rejected frame");
        frame(40, 1000, 0, 1, "R10 next frame clean");
        idle(2); promisc = 1'b1;
        frame(40, 5, 4, 1, "R4 promiscuous accept");
        idle(2); promisc = 1'b0; full_duplex = 1'b1;
        frame(40, 5, 4, 1, "R5 full duplex without padding");
        idle(2); fd_pad_en = 1'b1;
        frame(40, 5, 4, 0, "R5 full duplex with padding");
        idle(2); full_duplex = 1'b0; fd_pad_en = 1'b0; runt_accept = 1'b1;
        frame(40, 16, 3, 0, "R6 runt window last nibble");
        frame(40, 17, 3, 1, "R6 runt window closed");
        frame(12, 10, 3, 0, "R6 short runt frame rejected");
        idle(2); runt_accept = 1'b0;
        frame(40, 8, 0, 1, "R11 zero-length reject");
        frame(60, 30, 3, 0, "R11 delimiter nibble inside body ignored");
        idle(2); run_en = 1'b0;
        frame(40, 5, 4, -1, "R7 run disabled no strobe");
        idle(2); run_en = 1'b1;
        idle(3);
        g0 = glitches;
        @(negedge clk); reject_n = 1'b0;
        @(negedge clk); reject_n = 1'b0;
        @(negedge clk); reject_n = 1'b1;
        idle(3);
        chk(glitches == g0 + 1, "R8 two-cycle pulse flagged", glitches - g0, 1);
        g0 = glitches;
        for (int k = 0; k < 3; k++) begin @(negedge clk); reject_n = 1'b0; end
        idle(4);
        chk(glitches == g0, "R8 three-cycle pulse not flagged", glitches - g0, 0);
        g0 = glitches;
        run_en = 1'b0;
        @(negedge clk); reject_n = 1'b0;
        @(negedge clk); reject_n = 1'b1;
        idle(3);
        chk(glitches == g0, "R7 no glitch while disabled", glitches - g0, 0);
        run_en = 1'b1;
        idle(3);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule